// File: doc/BRIEF.md
# Hot-Plug I/O Expander Controller

This block keeps a set of hot-plug control outputs and status inputs in step with an external I/O expander on a single-master SMBus segment. The port logic presents a parallel vector of requested output levels. Whenever any bit of that vector differs from the last image sent, the controller writes the complete output image to the expander. When the expander pulls its active-low interrupt line, the controller reads every input byte back. It then presents the full captured input vector to the port logic, with a one-cycle update strobe.

The controller drives a byte-level command interface toward a separate SMBus master engine. Each command is one of: start-plus-address, write one byte, read one byte, or stop. The command is held until the engine pulses `m_done`. The engine returns a NACK flag with each completion, and a data byte when the command is a read. Only one transaction is in flight at a time. The engine is assumed to be the only master on its segment, so there is no arbitration here. Hot-plug bits are grouped per downstream port, numbered 1 upward. Port p owns bits `[(p-1)*PER +: PER]` of each vector, and port 0 has none.

Top module: `hpx_ctrl`

## Requirements
- R1: After reset the outputs read `m_cmd_valid`=0, `in_vec`=0, `in_upd`=0 and `err`=0. No command is issued while `cfg_done` is low.
- R2: A write transaction runs in this order, with op codes START=0, WRITE=1, READ=2, STOP=3. First a START whose byte is `{DEV_ADDR, 1'b0}`. Then one WRITE per output byte, least significant byte first, with unused top bits sent as zero. Then a STOP.
- R3: Any difference between `out_req` and the last image sent starts exactly one write carrying the whole current `out_req`. An unchanged `out_req` starts nothing.
- R4: If `out_req` changes one or more times while a write is in flight, exactly one further write follows, and it carries the latest value.
- R5: The interrupt pin is active low and passes through a two-flop synchronizer. A low level starts a read: a START with byte `{DEV_ADDR, 1'b1}`, then one READ per input byte (least significant first, with `m_cmd_last`=1 only on the final one), then a STOP.
- R6: `in_vec` changes only together with a one-cycle `in_upd` pulse. That pulse comes in the cycle after the STOP of a read completes with no NACK, and `in_vec` then holds the whole newly read image.
- R7: If the interrupt pin is still low when a read completes, another read starts.
- R8: When a write and a read are both pending, the write goes first.
- R9: A command is held stable until `m_done`. Each command produces exactly one completion, and no second transaction overlaps the first.
- R10: A NACK on a START or on a WRITE byte ends the attempt with a STOP. The whole transaction is then retried once, and `err` stays low if the retry succeeds.
- R11: A NACK on the retry as well sets `err`, which is sticky until reset. The controller returns to idle, and a failed read leaves `in_vec` unchanged with no `in_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Initial configuration load finished |
| out_req | input | OUT_W | Requested hot-plug output levels |
| exp_int_n | input | 1 | Active-low expander interrupt |
| in_vec | output | IN_W | Captured hot-plug input levels |
| in_upd | output | 1 | One-cycle pulse when `in_vec` is refreshed |
| err | output | 1 | Sticky failure after a NACKed retry |
| m_cmd_valid | output | 1 | Command presented to the SMBus engine |
| m_cmd_op | output | 2 | Command op: 0 start, 1 write, 2 read, 3 stop |
| m_cmd_byte | output | 8 | Address byte or write data |
| m_cmd_last | output | 1 | Final read byte (master NACKs it) |
| m_done | input | 1 | Engine completed the current command |
| m_nack | input | 1 | Slave did not acknowledge (with `m_done`) |
| m_rdata | input | 8 | Read data byte (with `m_done`) |

## Verification
A corrupted snapshot image shows on the bus. It appears as a spurious or missing write, or as wrong data bytes within one transaction of the fault. A stuck byte index shows as a command sequence of the wrong length or as a missing `m_cmd_last`, both visible before the STOP. A wrong retry flag shows as a third attempt, or as `err` rising after a single NACK, within two transactions. Wrong shadow handling shows as `in_vec` moving without a strobe, or as data changing after a failed read. The bench compares every logged command against an expected sequence built from the requirements.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_STOP
  } st_e;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpx_bytesel.sv
module hpx_bytesel #(
  parameter int W  = 46,
  parameter int NB = (W + 7) / 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  input  logic [IW-1:0] idx,
  output logic [7:0]    byte_o
);
  localparam int PW = NB * 8;

  logic [PW-1:0] pad;
  logic [7:0]    lanes [NB];

  always_comb begin
    pad        = '0;
    pad[W-1:0] = vec;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = pad[8*g +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NB; k++)
      if (idx == IW'(k)) byte_o = lanes[k];
  end
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
  import hpx_pkg::*;
#(
  parameter int         OUT_W    = 46,
  parameter int         IN_W     = 46,
  parameter logic [6:0] DEV_ADDR = 7'h27,
  parameter int         IW       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic [OUT_W-1:0] out_req,
  input  logic             int_act,
  input  logic [7:0]       wr_byte,
  output logic [OUT_W-1:0] snap,
  output logic [IW-1:0]    idx,
  output logic [IN_W-1:0]  in_vec,
  output logic             in_upd,
  output logic             err,
  output logic             m_cmd_valid,
  output logic [1:0]       m_cmd_op,
  output logic [7:0]       m_cmd_byte,
  output logic             m_cmd_last,
  input  logic             m_done,
  input  logic             m_nack,
  input  logic [7:0]       m_rdata
);
  localparam int NB_O = (OUT_W + 7) / 8;
  localparam int NB_I = (IN_W + 7) / 8;

  st_e             st;
  logic            rd_q, nacked, retried;
  logic [8*NB_I-1:0] shadow;
  logic            wr_pend;
  logic [IW-1:0]   last_idx;

  assign wr_pend  = (out_req != snap);
  assign last_idx = rd_q ? IW'(NB_I - 1) : IW'(NB_O - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rd_q    <= 1'b0;
      nacked  <= 1'b0;
      retried <= 1'b0;
      idx     <= '0;
      snap    <= '0;
      shadow  <= '0;
      in_vec  <= '0;
      in_upd  <= 1'b0;
      err     <= 1'b0;
    end else begin
      in_upd <= 1'b0;
      case (st)
        ST_IDLE: begin
          nacked  <= 1'b0;
          retried <= 1'b0;
          if (cfg_done && wr_pend) begin
            snap <= out_req;
            rd_q <= 1'b0;
            st   <= ST_ADDR;
          end else if (cfg_done && int_act) begin
            rd_q <= 1'b1;
            st   <= ST_ADDR;
          end
        end
        ST_ADDR: if (m_done) begin
          idx <= '0;
          if (m_nack) begin
            nacked <= 1'b1;
            st     <= ST_STOP;
          end else begin
            st <= ST_DATA;
          end
        end
        ST_DATA: if (m_done) begin
          if (rd_q) shadow[8*idx +: 8] <= m_rdata;
          if (!rd_q && m_nack) begin
            nacked <= 1'b1;
            st     <= ST_STOP;
          end else if (idx == last_idx) begin
            st <= ST_STOP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_STOP: if (m_done) begin
          if (nacked) begin
            nacked <= 1'b0;
            if (!retried) begin
              retried <= 1'b1;
              st      <= ST_ADDR;
            end else begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end
          end else begin
            if (rd_q) begin
              in_vec <= shadow[IN_W-1:0];
              in_upd <= 1'b1;
            end
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    m_cmd_valid = (st != ST_IDLE);
    m_cmd_op    = OP_STOP;
    m_cmd_byte  = '0;
    m_cmd_last  = 1'b0;
    case (st)
      ST_ADDR: begin
        m_cmd_op   = OP_START;
        m_cmd_byte = {DEV_ADDR, rd_q};
      end
      ST_DATA: begin
        m_cmd_op   = rd_q ? OP_READ : OP_WRITE;
        m_cmd_byte = rd_q ? 8'h00 : wr_byte;
        m_cmd_last = rd_q && (idx == last_idx);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl #(
  parameter int         PORTS    = 23,
  parameter int         OUT_PER  = 2,
  parameter int         IN_PER   = 2,
  parameter logic [6:0] DEV_ADDR = 7'h27,
  parameter int         SYNC_N   = 2,
  localparam int        OUT_W    = PORTS * OUT_PER,
  localparam int        IN_W     = PORTS * IN_PER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic [OUT_W-1:0] out_req,
  input  logic             exp_int_n,
  output logic [IN_W-1:0]  in_vec,
  output logic             in_upd,
  output logic             err,
  output logic             m_cmd_valid,
  output logic [1:0]       m_cmd_op,
  output logic [7:0]       m_cmd_byte,
  output logic             m_cmd_last,
  input  logic             m_done,
  input  logic             m_nack,
  input  logic [7:0]       m_rdata
);
  localparam int NB_O   = (OUT_W + 7) / 8;
  localparam int NB_I   = (IN_W + 7) / 8;
  localparam int NB_MAX = (NB_O > NB_I) ? NB_O : NB_I;
  localparam int IW     = $clog2(NB_MAX + 1);

  logic             int_n_s;
  logic [OUT_W-1:0] snap;
  logic [IW-1:0]    idx;
  logic [7:0]       wr_byte;

  hpx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(exp_int_n), .q(int_n_s)
  );

  hpx_bytesel #(.W(OUT_W), .NB(NB_O), .IW(IW)) u_sel (
    .vec(snap), .idx(idx), .byte_o(wr_byte)
  );

  hpx_seq #(.OUT_W(OUT_W), .IN_W(IN_W), .DEV_ADDR(DEV_ADDR), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .out_req(out_req),
    .int_act(!int_n_s), .wr_byte(wr_byte), .snap(snap), .idx(idx),
    .in_vec(in_vec), .in_upd(in_upd), .err(err),
    .m_cmd_valid(m_cmd_valid), .m_cmd_op(m_cmd_op), .m_cmd_byte(m_cmd_byte),
    .m_cmd_last(m_cmd_last), .m_done(m_done), .m_nack(m_nack), .m_rdata(m_rdata)
  );
endmodule

// File: rtl/hpx_ctrl_chk.sv
module hpx_ctrl_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h27,
  parameter int         IN_W     = 46
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_done,
  input logic [IN_W-1:0] in_vec,
  input logic            in_upd,
  input logic            err,
  input logic            m_cmd_valid,
  input logic [1:0]      m_cmd_op,
  input logic [7:0]      m_cmd_byte,
  input logic            m_cmd_last,
  input logic            m_done,
  input logic            m_nack
);
  a_r1_idle_before_cfg: assert property (@(posedge clk) disable iff (rst)
    (!cfg_done && !m_cmd_valid) |=> !m_cmd_valid);

  a_r9_hold_cmd: assert property (@(posedge clk) disable iff (rst)
    (m_cmd_valid && !m_done) |=> (m_cmd_valid && $stable(m_cmd_op) && $stable(m_cmd_byte)));

  a_r2_addr_byte: assert property (@(posedge clk) disable iff (rst)
    (m_cmd_valid && m_cmd_op == 2'd0) |-> (m_cmd_byte[7:1] == DEV_ADDR));

  a_r5_last_on_read: assert property (@(posedge clk) disable iff (rst)
    m_cmd_last |-> (m_cmd_valid && m_cmd_op == 2'd2));

  a_r6_upd_pulse: assert property (@(posedge clk) disable iff (rst)
    in_upd |=> !in_upd);

  a_r6_vec_with_upd: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_vec) |-> in_upd);

  a_r6_upd_after_stop: assert property (@(posedge clk) disable iff (rst)
    in_upd |-> ($past(m_done) && $past(m_cmd_op) == 2'd3 && !$past(m_nack)));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind hpx_ctrl hpx_ctrl_chk #(.DEV_ADDR(DEV_ADDR), .IN_W(IN_W)) u_chk (.*);

// File: tb/hpx_ctrl_bench.sv
module hpx_ctrl_bench;
  localparam int         PORTS = 23;
  localparam int         OUT_W = PORTS * 2;
  localparam int         IN_W  = PORTS * 2;
  localparam int         NB_O  = (OUT_W + 7) / 8;
  localparam int         NB_I  = (IN_W + 7) / 8;
  localparam logic [6:0] ADDR  = 7'h27;

  logic clk = 0, rst = 1, cfg_done = 0, exp_int_n = 1;
  logic [OUT_W-1:0] out_req = '0;
  logic [IN_W-1:0]  in_vec;
  logic in_upd, err, m_cmd_valid, m_cmd_last;
  logic [1:0] m_cmd_op;
  logic [7:0] m_cmd_byte;
  logic m_done = 0, m_nack = 0;
  logic [7:0] m_rdata = '0;

  hpx_ctrl u_hpx_ctrl (.*);

  always #5 clk = ~clk;

  // engine model
  logic [1:0] op_log [0:511];
  logic [7:0] by_log [0:511];
  logic       ls_log [0:511];
  int nlog = 0, dly = 0, rd_cnt = 0, upd_cnt = 0, nack_used = 0, nack_req = 0;
  logic [1:0] nack_op = 2'd0;
  logic [8*NB_I-1:0] rd_img = '0;
  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_done <= 0; m_nack <= 0; dly <= 0; rd_cnt <= 0;
    end else begin
      m_done <= 0; m_nack <= 0;
      if (m_cmd_valid && !m_done) begin
        if (dly == 2) begin
          dly <= 0;
          m_done <= 1;
          op_log[nlog] <= m_cmd_op;
          by_log[nlog] <= m_cmd_byte;
          ls_log[nlog] <= m_cmd_last;
          nlog <= nlog + 1;
          if (m_cmd_op == 2'd0) rd_cnt <= 0;
          if (m_cmd_op == 2'd2) begin
            if (rd_cnt < NB_I) m_rdata <= rd_img[8*rd_cnt +: 8];
            rd_cnt <= rd_cnt + 1;
          end
          if (nack_used < nack_req && m_cmd_op == nack_op) begin
            m_nack <= 1;
            nack_used <= nack_used + 1;
          end
        end else dly <= dly + 1;
      end
    end
  end

  always @(posedge clk) if (!rst && in_upd) upd_cnt <= upd_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      q = m_cmd_valid ? 0 : q + 1;
    end
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) @(negedge clk);
  endtask

  function automatic int count_starts(input int base, input int kind);
    int n = 0;
    for (int i = base; i < nlog; i++)
      if (op_log[i] == 2'd0 && (kind < 0 || by_log[i][0] == kind[0])) n++;
    return n;
  endfunction

  task automatic chk_write(input int s, input logic [OUT_W-1:0] img, input string tag);
    logic [63:0] act = '0;
    bit ok = (op_log[s] == 2'd0) && (by_log[s] == {ADDR, 1'b0}) && (op_log[s+NB_O+1] == 2'd3);
    for (int k = 0; k < NB_O; k++) begin
      act[8*k +: 8] = by_log[s+1+k];
      if (op_log[s+1+k] != 2'd1) ok = 0;
    end
    check(ok && act == 64'(img), tag, act, 64'(img));
  endtask

  task automatic chk_read(input int s, input string tag);
    bit ok = (op_log[s] == 2'd0) && (by_log[s] == {ADDR, 1'b1}) && (op_log[s+NB_I+1] == 2'd3);
    for (int k = 0; k < NB_I; k++)
      if (op_log[s+1+k] != 2'd2 || ls_log[s+1+k] != (k == NB_I - 1)) ok = 0;
    check(ok, tag, {op_log[s], by_log[s]}, {2'd0, ADDR, 1'b1});
  endtask

  task automatic t_reset();
    check(!m_cmd_valid && in_vec == '0 && !in_upd && !err, "R1 reset outputs",
          {m_cmd_valid, in_upd, err}, 0);
    out_req = 46'h1234_5678_9ABC;
    repeat (30) @(negedge clk);
    check(nlog == 0, "R1 no command before cfg_done", nlog, 0);
    cfg_done = 1;
    wait_quiet();
    check(count_starts(0, -1) == 1, "R3 one write after cfg_done", count_starts(0, -1), 1);
    chk_write(0, 46'h1234_5678_9ABC, "R2 write sequence");
  endtask

  task automatic t_change();
    int base = nlog;
    out_req = 46'h2AAA_0F0F_5501;
    wait_quiet();
    check(count_starts(base, -1) == 1, "R3 one write per change", count_starts(base, -1), 1);
    check(nlog - base == NB_O + 2, "R9 one completion per command", nlog - base, NB_O + 2);
    chk_write(base, 46'h2AAA_0F0F_5501, "R3 full image written");
    base = nlog;
    repeat (60) @(negedge clk);
    check(nlog == base, "R3 unchanged request idle", nlog - base, 0);
  endtask

  task automatic t_dirty();
    int base = nlog;
    out_req = 46'h0000_0000_00C3;
    wait_log(base + 2);
    out_req = 46'h0001_0000_0000;
    repeat (3) @(negedge clk);
    out_req = 46'h3FFF_FFFF_FFFF;
    wait_quiet();
    check(count_starts(base, -1) == 2, "R4 exactly one follow-up write", count_starts(base, -1), 2);
    chk_write(base, 46'h0000_0000_00C3, "R4 first write keeps snapshot");
    chk_write(base + NB_O + 2, 46'h3FFF_FFFF_FFFF, "R4 follow-up carries latest");
  endtask

  task automatic t_read();
    int base = nlog, u0 = upd_cnt;
    rd_img = 48'h1357_9BDF_0246;
    exp_int_n = 0;
    wait_log(base + 1);
    exp_int_n = 1;
    wait_quiet();
    check(count_starts(base, 1) == 1 && count_starts(base, 0) == 0, "R5 one read",
          count_starts(base, 1), 1);
    chk_read(base, "R5 read sequence");
    check(in_vec == 46'h1357_9BDF_0246, "R6 captured image", in_vec, 46'h1357_9BDF_0246);
    check(upd_cnt == u0 + 1, "R6 single strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_reread();
    int base = nlog, u0 = upd_cnt;
    rd_img = 48'h2468_ACE1_3579;
    exp_int_n = 0;
    while (upd_cnt < u0 + 2) @(negedge clk);
    exp_int_n = 1;
    wait_quiet();
    check(count_starts(base, 1) >= 2, "R7 read repeats while low", count_starts(base, 1), 2);
    check(in_vec == 46'h2468_ACE1_3579, "R7 image after reread", in_vec, 46'h2468_ACE1_3579);
  endtask

  task automatic t_prio();
    int base = nlog;
    rd_img = 48'h0000_1111_2222;
    exp_int_n = 0;
    wait_log(base + 1);
    out_req = 46'h1555_5555_5555;
    wait_log(base + NB_I + 3);
    exp_int_n = 1;
    wait_quiet();
    check(op_log[base + NB_I + 2] == 2'd0 && by_log[base + NB_I + 2][0] == 1'b0,
          "R8 write before pending read", by_log[base + NB_I + 2], {ADDR, 1'b0});
    check(count_starts(base, -1) == 2, "R8 two transactions", count_starts(base, -1), 2);
    chk_write(base + NB_I + 2, 46'h1555_5555_5555, "R8 write image");
  endtask

  task automatic t_nack_start();
    int base = nlog;
    nack_op = 2'd0; nack_req = nack_used + 1;
    out_req = 46'h0ABC_DEF0_1234;
    wait_quiet();
    check(op_log[base] == 2'd0 && op_log[base+1] == 2'd3, "R10 NACKed start then stop",
          {op_log[base], op_log[base+1]}, {2'd0, 2'd3});
    chk_write(base + 2, 46'h0ABC_DEF0_1234, "R10 retry after start NACK");
    check(!err, "R10 no error after good retry", err, 0);
  endtask

  task automatic t_nack_data();
    int base = nlog;
    nack_op = 2'd1; nack_req = nack_used + 1;
    out_req = 46'h0000_0000_BEEF;
    wait_quiet();
    check(op_log[base+1] == 2'd1 && op_log[base+2] == 2'd3, "R10 NACKed byte then stop",
          {op_log[base+1], op_log[base+2]}, {2'd1, 2'd3});
    chk_write(base + 3, 46'h0000_0000_BEEF, "R10 retry after byte NACK");
  endtask

  task automatic t_fail();
    int base = nlog, u0 = upd_cnt;
    logic [IN_W-1:0] old = in_vec;
    nack_op = 2'd0; nack_req = nack_used + 2;
    rd_img = 48'hFFFF_0000_FFFF;
    exp_int_n = 0;
    wait_log(base + 1);
    exp_int_n = 1;
    wait_quiet();
    check(nlog - base == 4 && count_starts(base, 1) == 2, "R11 two attempts only",
          nlog - base, 4);
    check(err, "R11 error set", err, 1);
    check(in_vec == old && upd_cnt == u0, "R11 failed read discarded", in_vec, old);
    base = nlog;
    out_req = 46'h0101_0101_0101;
    wait_quiet();
    chk_write(base, 46'h0101_0101_0101, "R11 idle resumes service");
    check(err, "R11 error sticky", err, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_change();
    t_dirty();
    t_read();
    t_reread();
    t_prio();
    t_nack_start();
    t_nack_data();
    t_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule